// File: doc/BRIEF.md
# Working Register File with Address Pointers

This block holds the thirty-two 8-bit working registers of a small single-cycle RISC datapath. Two combinational byte read ports and a combinational 16-bit read port serve the operand fetch, while one write port stores either a single byte or a full register pair on a clock edge. All state updates are registered, and a read issued in the same cycle as a write to the same register still returns the value held before that edge.

The six highest registers double as three 16-bit address pointers, with the even register as the low byte and the odd register as the high byte. A selected pointer can be used as it is, advanced by one after use, or stepped back by one before use. The block drives the effective address and writes the updated pointer back on the clock edge. Both steps wrap modulo 2^16.

The file is also mapped into the bottom of the data address space. A byte load or store whose address is below 0x20 goes to the register with that index. Every higher address, including the I/O range 0x20 to 0x5F, misses the file. This lets a pointer address the register file itself.

Top module: `gpr_file_ptr`

## Requirements
- R1: While rst_n is low at a rising clock edge, every register becomes 0x00 on that edge. Reset is synchronous, so the contents do not change before the edge.
- R2: A byte write (wr_en=1, wr_wide=0) stores wr_data[7:0] in register wr_idx. From the next cycle, both rd_a_data and rd_b_data return it for that index.
- R3: A pair write (wr_en=1, wr_wide=1) stores wr_data[7:0] in register {wr_idx[4:1],0} and wr_data[15:8] in register {wr_idx[4:1],1} on the same edge. rd_word_data returns {odd, even} of the pair that rd_a_idx[4:1] selects.
- R4: When a write and a read hit the same register in one cycle, the read returns the value held before the edge. The new value appears in the following cycle.
- R5: ptr_sel encodes 0 for the pair 26/27, 1 for the pair 28/29 and 2 for the pair 30/31. ptr_mode encodes 0 as plain, 1 as post-increment, 2 as pre-decrement and 3 as plain. In plain mode ptr_addr equals the pair value and no update happens.
- R6: With ptr_en=1 and post-increment, ptr_addr equals the current pair value, and the pair holds that value plus one after the edge.
- R7: With ptr_en=1 and pre-decrement, ptr_addr equals the pair value minus one, and the pair holds that same value after the edge.
- R8: Increment of 0xFFFF gives 0x0000, and decrement of 0x0000 gives 0xFFFF.
- R9: For ds_addr below 0x20, ds_hit is 1 and ds_rd_data returns register ds_addr. With ds_we=1, ds_wdata is stored there on the edge.
- R10: For ds_addr of 0x20 or higher, ds_hit is 0 and ds_rd_data is 0x00. A ds_we in that cycle changes no register.
- R11: When several sources write one register on the same edge, the pointer update wins over the write port, and the write port wins over the data-space store.
- R12: With ptr_sel=3, ptr_addr is 0x0000 and nothing is updated. With ptr_en=0, no pointer register changes whatever the mode is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Register index for read port A, also selects the pair for the word read |
| rd_a_data | output | 8 | Byte at rd_a_idx |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Byte at rd_b_idx |
| rd_word_data | output | 16 | Pair selected by rd_a_idx[4:1], odd byte high |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | 1 writes a whole pair, 0 writes one byte |
| wr_idx | input | 5 | Write target register, or the pair through bits 4:1 |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| ds_addr | input | 16 | Data-space address of a load or store |
| ds_we | input | 1 | Data-space store strobe |
| ds_wdata | input | 8 | Data-space store byte |
| ds_rd_data | output | 8 | Data-space load byte, 0x00 on a miss |
| ds_hit | output | 1 | ds_addr falls inside the register window |
| ptr_en | input | 1 | Apply the pointer update this cycle |
| ptr_sel | input | 2 | Pointer select: 0, 1, 2 or 3 for none |
| ptr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 plain |
| ptr_addr | output | 16 | Effective address from the selected pointer |

## Verification
A corrupted register shows on rd_a_data, rd_b_data or ds_rd_data as soon as it is selected, and a bad pair shows on rd_word_data and ptr_addr in the same cycle. A wrong pointer step or a wrong write priority shows one cycle later, when the pair is read back. A window decode that aliases high addresses onto low indices shows as an unexpected change in register 0 or register 31 on the cycle after the stray store. Sequences that chain pointer steps carry an off-by-one error forward into every later effective address.

// File: rtl/gpr_pkg.sv
// Shared encodings for the working register file.
// Assumes 2-bit select and mode fields on the top-level ports.
package gpr_pkg;
    typedef enum logic [1:0] {
        PTR_LO   = 2'd0,
        PTR_MID  = 2'd1,
        PTR_HI   = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        PM_PLAIN   = 2'd0,
        PM_POSTINC = 2'd1,
        PM_PREDEC  = 2'd2,
        PM_RSVD    = 2'd3
    } ptr_mode_e;
endpackage

// File: rtl/gpr_storage.sv
// Flip-flop array of NREG registers of W bits, each with its own write enable.
// Assumes the caller has already resolved write conflicts per byte.
module gpr_storage #(
    parameter int NREG = 32,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   byte_we,
    input  logic [NREG*W-1:0] byte_wd,
    output logic [NREG*W-1:0] q_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] cell_q;

        // Hold one register; synchronous clear, else load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (byte_we[g]) begin
                cell_q <= byte_wd[g*W +: W];
            end
        end

        assign q_flat[g*W +: W] = cell_q;
    end
endmodule

// File: rtl/gpr_ptr_unit.sv
// Effective-address and next-value logic for one selected 16-bit pointer.
// Assumes the caller gates the update with its own enable and selection.
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] cur,
    input  ptr_mode_e     mode,
    output logic [PW-1:0] eff,
    output logic [PW-1:0] nxt,
    output logic          upd
);
    // Choose the address seen by the access and the value written back.
    always_comb begin
        eff = cur;
        nxt = cur;
        upd = 1'b0;
        case (mode)
            PM_POSTINC: begin
                nxt = cur + PW'(1);
                upd = 1'b1;
            end
            PM_PREDEC: begin
                eff = cur - PW'(1);
                nxt = cur - PW'(1);
                upd = 1'b1;
            end
            default: begin
                upd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gpr_ds_window.sv
// Decodes a data-space address into a register-file hit and index.
// Assumes the file occupies addresses 0 .. NREG-1.
module gpr_ds_window #(
    parameter int AW   = 16,
    parameter int NREG = 32,
    parameter int IDXW = 5
) (
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    localparam logic [AW-1:0] WIN_END = AW'(NREG);

    // Compare the full address so higher regions never alias onto the file.
    always_comb begin
        hit = (addr < WIN_END);
        idx = addr[IDXW-1:0];
    end
endmodule

// File: rtl/gpr_file_ptr.sv
// Working register file: two byte reads, one word read, and one byte or pair write.
// The top pairs serve as 16-bit pointers with post-increment and pre-decrement,
// and the file is mapped at the bottom of data space.
// Assumes a single clock; write priority is pointer > write port > data-space store.
module gpr_file_ptr
    import gpr_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int W        = 8,
    parameter int AW       = 16,
    parameter int PTR_BASE = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_idx,
    output logic [7:0]        rd_a_data,
    input  logic [4:0]        rd_b_idx,
    output logic [7:0]        rd_b_data,
    output logic [15:0]       rd_word_data,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [4:0]        wr_idx,
    input  logic [15:0]       wr_data,
    input  logic [15:0]       ds_addr,
    input  logic              ds_we,
    input  logic [7:0]        ds_wdata,
    output logic [7:0]        ds_rd_data,
    output logic              ds_hit,
    input  logic              ptr_en,
    input  logic [1:0]        ptr_sel,
    input  logic [1:0]        ptr_mode,
    output logic [15:0]       ptr_addr
);
    localparam int IDXW = $clog2(NREG);
    localparam int PW   = 2 * W;
    localparam logic [IDXW-2:0] PTR_PAIR0 = (IDXW-1)'(PTR_BASE / 2);

    logic [NREG*W-1:0] q_flat;
    logic [NREG-1:0]   byte_we;
    logic [NREG*W-1:0] byte_wd;

    logic              win_hit;
    logic [IDXW-1:0]   win_idx;
    logic              ds_wr_hit;

    ptr_sel_e          sel_e;
    logic              sel_ok;
    logic [IDXW-2:0]   ptr_pair;
    logic [PW-1:0]     ptr_cur;
    logic [PW-1:0]     ptr_eff;
    logic [PW-1:0]     ptr_nxt;
    logic              ptr_step;
    logic              ptr_upd;

    gpr_storage #(.NREG(NREG), .W(W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (byte_we),
        .byte_wd (byte_wd),
        .q_flat  (q_flat)
    );

    gpr_ds_window #(.AW(AW), .NREG(NREG), .IDXW(IDXW)) u_win (
        .addr (ds_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    gpr_ptr_unit #(.PW(PW)) u_ptr (
        .cur  (ptr_cur),
        .mode (ptr_mode_e'(ptr_mode)),
        .eff  (ptr_eff),
        .nxt  (ptr_nxt),
        .upd  (ptr_step)
    );

    // Resolve the pointer selection into a pair index and its current value.
    always_comb begin
        sel_e    = ptr_sel_e'(ptr_sel);
        sel_ok   = (sel_e != PTR_NONE);
        ptr_pair = PTR_PAIR0 + (sel_ok ? (IDXW-1)'(ptr_sel) : '0);
        ptr_cur  = sel_ok ? q_flat[ptr_pair*PW +: PW] : '0;
        ptr_upd  = ptr_en && sel_ok && ptr_step;
        ptr_addr = sel_ok ? ptr_eff : '0;
    end

    // Combinational read ports and the data-space load path.
    always_comb begin
        rd_a_data    = q_flat[rd_a_idx*W +: W];
        rd_b_data    = q_flat[rd_b_idx*W +: W];
        rd_word_data = q_flat[rd_a_idx[IDXW-1:1]*PW +: PW];
        ds_hit       = win_hit;
        ds_rd_data   = win_hit ? q_flat[win_idx*W +: W] : '0;
        ds_wr_hit    = ds_we && win_hit;
    end

    // Merge the three write sources per byte; later assignments take priority.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            byte_we[i]         = 1'b0;
            byte_wd[i*W +: W]  = '0;
            if (ds_wr_hit && (win_idx == i[IDXW-1:0])) begin
                byte_we[i]        = 1'b1;
                byte_wd[i*W +: W] = ds_wdata;
            end
            if (wr_en) begin
                if (wr_wide && (wr_idx[IDXW-1:1] == i[IDXW-1:1])) begin
                    byte_we[i]        = 1'b1;
                    byte_wd[i*W +: W] = i[0] ? wr_data[PW-1:W] : wr_data[W-1:0];
                end else if (!wr_wide && (wr_idx == i[IDXW-1:0])) begin
                    byte_we[i]        = 1'b1;
                    byte_wd[i*W +: W] = wr_data[W-1:0];
                end
            end
            if (ptr_upd && (ptr_pair == i[IDXW-1:1])) begin
                byte_we[i]        = 1'b1;
                byte_wd[i*W +: W] = i[0] ? ptr_nxt[PW-1:W] : ptr_nxt[W-1:0];
            end
        end
    end
endmodule

// File: rtl/gpr_file_ptr_chk.sv
// Temporal checks on the register file, attached to every instance by bind.
// Assumes it observes the flat register contents of the storage array.
module gpr_file_ptr_chk #(
    parameter int NREG     = 32,
    parameter int W        = 8,
    parameter int PTR_BASE = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_wide,
    input logic [4:0]        wr_idx,
    input logic [15:0]       wr_data,
    input logic              ds_we,
    input logic              ds_hit,
    input logic              ptr_en,
    input logic [1:0]        ptr_sel,
    input logic [1:0]        ptr_mode,
    input logic [15:0]       ptr_addr,
    input logic [NREG*W-1:0] regs_q
);
    localparam int PW = 2 * W;

    function automatic logic [PW-1:0] pair_of(input logic [1:0] s);
        return regs_q[(PTR_BASE / 2 + int'(s)) * PW +: PW];
    endfunction

    function automatic logic [W-1:0] byte_of(input logic [4:0] k);
        return regs_q[int'(k) * W +: W];
    endfunction

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));

    // R2
    byte_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && !ptr_en && !ds_we)
        |=> (byte_of($past(wr_idx)) == $past(wr_data[7:0])));

    // R6
    post_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_sel != 2'd3 && ptr_mode == 2'd1 && !wr_en && !ds_we)
        |=> (pair_of($past(ptr_sel)) == PW'($past(ptr_addr) + 16'd1)));

    // R7
    pre_dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_sel != 2'd3 && ptr_mode == 2'd2 && !wr_en && !ds_we)
        |=> (pair_of($past(ptr_sel)) == $past(ptr_addr)));

    // R10
    miss_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && !ds_hit && !wr_en && !ptr_en)
        |=> $stable(regs_q));
endmodule

bind gpr_file_ptr gpr_file_ptr_chk #(
    .NREG     (NREG),
    .W        (W),
    .PTR_BASE (PTR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .ds_we    (ds_we),
    .ds_hit   (ds_hit),
    .ptr_en   (ptr_en),
    .ptr_sel  (ptr_sel),
    .ptr_mode (ptr_mode),
    .ptr_addr (ptr_addr),
    .regs_q   (q_flat)
);

// File: tb/sim_gpr_file_ptr.sv
// Self-checking bench for the working register file.
module sim_gpr_file_ptr;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [7:0]  rd_a_data, rd_b_data, ds_wdata, ds_rd_data;
    logic [15:0] rd_word_data, wr_data, ds_addr, ptr_addr;
    logic        wr_en, wr_wide, ds_we, ds_hit, ptr_en;
    logic [1:0]  ptr_sel, ptr_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpr_file_ptr u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_word_data(rd_word_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rd_data(ds_rd_data), .ds_hit(ds_hit),
        .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_addr(ptr_addr)
    );

    // Byte write table: {index, data}, read back on both ports and through data space.
    localparam logic [12:0] TBL [8] = '{
        {5'd0,  8'hA5}, {5'd1,  8'h3C}, {5'd7,  8'h81}, {5'd15, 8'hF0},
        {5'd16, 8'h0F}, {5'd25, 8'h5A}, {5'd26, 8'hC3}, {5'd31, 8'h7E}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
        ds_addr = 16'hFFFF; ds_we = 0; ds_wdata = 0;
        ptr_en = 0; ptr_sel = 2'd3; ptr_mode = 0;
    endtask

    task automatic step();
        @(posedge clk); #1; idle();
    endtask

    task automatic wr8(input logic [4:0] k, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_wide = 0; wr_idx = k; wr_data = {8'h00, d};
        step();
    endtask

    task automatic wr16(input logic [4:0] k, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_wide = 1; wr_idx = k; wr_data = d;
        step();
    endtask

    task automatic rd8(input logic [4:0] k, output logic [7:0] v);
        rd_a_idx = k; #1; v = rd_a_data;
    endtask

    task automatic rdw(input logic [4:0] k, output logic [15:0] v);
        rd_a_idx = k; #1; v = rd_word_data;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        idle(); rd_a_idx = 0; rd_b_idx = 0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 32; i++) begin
            rd8(5'(i), b); chk("R1 reset value", {8'h00, b}, 16'h0000);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2 / R9: table walk
        for (int i = 0; i < 8; i++) begin
            wr8(TBL[i][12:8], TBL[i][7:0]);
            rd8(TBL[i][12:8], b);
            chk("R2 port A", {8'h00, b}, {8'h00, TBL[i][7:0]});
            rd_b_idx = TBL[i][12:8]; ds_addr = {11'd0, TBL[i][12:8]}; #1;
            chk("R2 port B", {8'h00, rd_b_data}, {8'h00, TBL[i][7:0]});
            chk("R9 ds load", {7'd0, ds_hit, ds_rd_data}, {7'd0, 1'b1, TBL[i][7:0]});
        end

        // R3: pair write and word read
        wr16(5'd10, 16'hBEEF);
        rdw(5'd10, w); chk("R3 word even idx", w, 16'hBEEF);
        rdw(5'd11, w); chk("R3 word odd idx", w, 16'hBEEF);
        rd8(5'd11, b); chk("R3 high byte", {8'h00, b}, 16'h00BE);

        // R4: read during write returns old value
        @(negedge clk); wr_en = 1; wr_idx = 5'd3; wr_data = 16'h0055; rd_a_idx = 5'd3; #1;
        chk("R4 old value same cycle", {8'h00, rd_a_data}, 16'h0000);
        step();
        rd8(5'd3, b); chk("R4 new value next cycle", {8'h00, b}, 16'h0055);

        // R5: pointer mapping and plain mode
        wr16(5'd26, 16'h1234); wr16(5'd28, 16'h5678); wr16(5'd30, 16'h9ABC);
        @(negedge clk); ptr_sel = 2'd0; ptr_mode = 2'd0; #1; chk("R5 pair 26", ptr_addr, 16'h1234);
        ptr_sel = 2'd1; #1; chk("R5 pair 28", ptr_addr, 16'h5678);
        ptr_sel = 2'd2; ptr_mode = 2'd3; ptr_en = 1; #1; chk("R5 pair 30 mode3", ptr_addr, 16'h9ABC);
        step();
        rdw(5'd30, w); chk("R5 mode3 no update", w, 16'h9ABC);

        // R6: post-increment
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd1; ptr_mode = 2'd1; #1;
        chk("R6 eff before", ptr_addr, 16'h5678);
        step();
        rdw(5'd28, w); chk("R6 pair after", w, 16'h5679);

        // R7: pre-decrement
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd2; ptr_mode = 2'd2; #1;
        chk("R7 eff before", ptr_addr, 16'h9ABB);
        step();
        rdw(5'd30, w); chk("R7 pair after", w, 16'h9ABB);

        // R8: wrap both ways
        wr16(5'd26, 16'hFFFF);
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd1; step();
        rdw(5'd26, w); chk("R8 inc wrap", w, 16'h0000);
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd2; #1;
        chk("R8 dec eff wrap", ptr_addr, 16'hFFFF);
        step();
        rdw(5'd26, w); chk("R8 dec wrap", w, 16'hFFFF);

        // R9: data-space store
        @(negedge clk); ds_addr = 16'h001C; ds_we = 1; ds_wdata = 8'h77; step();
        rd8(5'd28, b); chk("R9 ds store", {8'h00, b}, 16'h0077);
        ds_addr = 16'h001F; #1; chk("R9 top of window", {15'd0, ds_hit}, 16'h0001);

        // R10: stores outside the window
        @(negedge clk); ds_addr = 16'h0020; ds_we = 1; ds_wdata = 8'h99; #1;
        chk("R10 miss 0x20", {7'd0, ds_hit, ds_rd_data}, 16'h0000);
        step();
        rd8(5'd0, b); chk("R10 reg0 kept", {8'h00, b}, 16'h00A5);
        @(negedge clk); ds_addr = 16'h005F; ds_we = 1; ds_wdata = 8'h99; step();
        rd8(5'd31, b); chk("R10 reg31 kept", {8'h00, b}, 16'h009A);
        @(negedge clk); ds_addr = 16'h0100; ds_we = 1; ds_wdata = 8'h99; step();
        rd8(5'd0, b); chk("R10 high addr", {8'h00, b}, 16'h00A5);

        // R11: write priority
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd2; ptr_mode = 2'd1;
        wr_en = 1; wr_idx = 5'd30; wr_data = 16'h0011;
        ds_addr = 16'h001E; ds_we = 1; ds_wdata = 8'h22; step();
        rdw(5'd30, w); chk("R11 pointer wins", w, 16'h9ABC);
        @(negedge clk); wr_en = 1; wr_idx = 5'd2; wr_data = 16'h0033;
        ds_addr = 16'h0002; ds_we = 1; ds_wdata = 8'h44; step();
        rd8(5'd2, b); chk("R11 port over store", {8'h00, b}, 16'h0033);

        // R12: no selection / no enable
        @(negedge clk); ptr_en = 1; ptr_sel = 2'd3; ptr_mode = 2'd1; #1;
        chk("R12 none addr", ptr_addr, 16'h0000);
        step();
        @(negedge clk); ptr_en = 0; ptr_sel = 2'd1; ptr_mode = 2'd2; step();
        rdw(5'd26, w); chk("R12 pair 26 kept", w, 16'hFFFF);
        rdw(5'd28, w); chk("R12 pair 28 kept", w, 16'h5677);
        rdw(5'd30, w); chk("R12 pair 30 kept", w, 16'h9ABC);

        // R1: synchronous reset mid-run
        @(negedge clk); rst_n = 1'b0; rd_a_idx = 5'd0; #1;
        chk("R1 sync hold", {8'h00, rd_a_data}, 16'h00A5);
        @(posedge clk); #1;
        rd8(5'd0, b);  chk("R1 cleared reg0", {8'h00, b}, 16'h0000);
        rdw(5'd30, w); chk("R1 cleared pair", w, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        finish_up();
    end
endmodule